// File: doc/BRIEF.md
# Half-Precision Max-Pooling Unit

This functional unit reduces a matrix of 16-bit half-precision values to a smaller matrix by taking the largest element of each square window. The input matrix is stored row-major in a memory whose read data returns in the same cycle as the address. Windows do not overlap, and each one steps across by exactly its own size. Results go row-major into a second region of the same memory.

A controller sets the source base address, the destination base address, the row and column counts and the window edge length, then raises `start` while `done` is high. The unit captures the configuration, runs through every window and raises `done` again when the last result has been written. Rows or columns that do not fill a whole window are skipped. Values are compared on their raw bit patterns. The sign decides first, then the exponent, then the mantissa. Each window's running maximum starts at +0.0.

Top module: `hpMaxPool`

## Requirements
- R1: After reset `done` is 1 and `wrEn` is 0.
- R2: When `start` is 1 while `done` is 1, `done` is 0 in the next cycle. It stays 0 until the last result of the job is written. While idle without `start`, `done` remains 1.
- R3: A window's result is its largest element under this ordering: a value with sign bit 15 clear beats one with it set. With equal signs, a larger exponent field (bits 14:10) wins, then a larger mantissa field (bits 9:0). For two negative values the magnitude order is reversed.
- R4: The running maximum starts each window at 16'h0000 and is replaced only by a strictly larger element. A window with no positive non-zero element therefore yields 16'h0000.
- R5: With a window edge of W on an R x C matrix, the unit writes exactly floor(R/W)*floor(C/W) results. They go to consecutive addresses starting at the destination base, in row-major window order.
- R6: Windows step by W in both directions. Trailing rows and columns that do not fill a window are not read into any result, and no write lands past the last result address.
- R7: A job takes 1 + N*(W*W+1) cycles from the edge that accepts `start` to the edge after which `done` is 1, where N is the number of windows. Each window uses W*W read cycles and one write cycle.
- R8: Element (r, c) is read from source base + r*C + c, for a non-zero source base.
- R9: `wrEn` is a single-cycle pulse and is never 1 while `done` is 1.
- R10: Configuration inputs are sampled only in the cycle that accepts `start`. Changes to them during a job have no effect on that job.
- R11: A `start` pulse during a running job is ignored. The results and the cycle count are those of the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (accepted while idle) |
| srcBase | input | ADDR_W | Address of element (0,0) of the input matrix |
| dstBase | input | ADDR_W | Address of the first result |
| numRows | input | DIM_W | Input matrix row count |
| numCols | input | DIM_W | Input matrix column count |
| winSize | input | DIM_W | Window edge length, at least 1 and no more than rows and columns |
| done | output | 1 | High while idle, low during a job |
| rdAddr | output | ADDR_W | Memory read address |
| rdData | input | 16 | Memory read data, valid in the same cycle |
| wrAddr | output | ADDR_W | Memory write address |
| wrData | output | 16 | Memory write data (window maximum) |
| wrEn | output | 1 | Memory write enable |

## Verification
A wrong window origin or a wrong offset counter shows as a wrong value in the destination region, which becomes visible as soon as that window's write cycle occurs. A scan counter that wraps at the wrong point shifts the write pulses, so the done edge moves away from 1 + N*(W*W+1). A window counter or a wrong total shows as a missing write or a write into the sentinel word past the last result. A stale running maximum carries one window's value into the next window's result. A faulty negative branch, or a maximum that is not cleared, makes an all-negative window write something other than 16'h0000, or makes a written word carry sign bit 1.

// File: rtl/hpPoolPkg.sv
package hpPoolPkg;

  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_WRITE = 2'd2,
    ST_IDLE  = 2'd3
  } poolState_e;

  typedef struct packed {
    logic loadCfg;   // capture configuration on accepted start
    logic initRun;   // reset job counters and pointers
    logic scanStep;  // consume one window element
    logic writeOut;  // emit window result and move to next window
  } poolCtrl_t;

  // True when half-precision pattern a orders strictly above b.
  function automatic logic halfGreater(input logic [HALF_W-1:0] a,
                                       input logic [HALF_W-1:0] b);
    logic expGt, expLt, mantGt, mantLt, magGt, magLt;
    expGt  = a[14:10] > b[14:10];
    expLt  = a[14:10] < b[14:10];
    mantGt = a[9:0] > b[9:0];
    mantLt = a[9:0] < b[9:0];
    magGt  = expGt | (!expLt & mantGt);
    magLt  = expLt | (!expGt & mantLt);
    if (a[15] != b[15]) return !a[15];
    else if (!a[15])    return magGt;
    else                return magLt;
  endfunction

endpackage

// File: rtl/hpPoolCtrl.sv
module hpPoolCtrl
  import hpPoolPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      scanLast,
  input  logic      lastWin,
  output poolCtrl_t ctrl,
  output logic      wrEn,
  output logic      done
);

  poolState_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_INIT;
          done  <= 1'b0;
        end
        ST_INIT: state <= ST_SCAN;
        ST_SCAN: if (scanLast) state <= ST_WRITE;
        ST_WRITE: begin
          if (lastWin) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.loadCfg  = (state == ST_IDLE) && start;
    ctrl.initRun  = (state == ST_INIT);
    ctrl.scanStep = (state == ST_SCAN);
    ctrl.writeOut = (state == ST_WRITE);
    wrEn          = (state == ST_WRITE);
  end

endmodule

// File: rtl/hpPoolDatapath.sv
module hpPoolDatapath
  import hpPoolPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  poolCtrl_t         ctrl,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [DIM_W-1:0]  numRows,
  input  logic [DIM_W-1:0]  numCols,
  input  logic [DIM_W-1:0]  winSize,
  input  logic [HALF_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [HALF_W-1:0] wrData,
  output logic              scanLast,
  output logic              lastWin
);

  localparam int CNT_W = 2 * DIM_W;
  localparam int EXT_W = DIM_W + 2;

  logic [ADDR_W-1:0] cfgSrc, cfgDst, dstPtr;
  logic [DIM_W-1:0]  cfgRows, cfgCols, cfgWin;
  logic [DIM_W-1:0]  rowBase, colBase, rowOff, colOff;
  logic [CNT_W-1:0]  totalWin, winCount;
  logic [HALF_W-1:0] maxVal;

  logic [DIM_W-1:0]  winSafe, winLast;
  logic [CNT_W-1:0]  outRows, outCols;
  logic              rowWrap;
  logic [ADDR_W-1:0] elemRow, elemCol;

  always_comb begin
    winSafe  = (cfgWin == '0) ? DIM_W'(1) : cfgWin;
    winLast  = cfgWin - DIM_W'(1);
    outRows  = CNT_W'(cfgRows / winSafe);
    outCols  = CNT_W'(cfgCols / winSafe);
    rowWrap  = (EXT_W'(colBase) + 2 * EXT_W'(cfgWin)) > EXT_W'(cfgCols);
    elemRow  = ADDR_W'(rowBase) + ADDR_W'(rowOff);
    elemCol  = ADDR_W'(colBase) + ADDR_W'(colOff);
    rdAddr   = cfgSrc + elemRow * ADDR_W'(cfgCols) + elemCol;
    wrAddr   = dstPtr;
    wrData   = maxVal;
    scanLast = (rowOff == winLast) && (colOff == winLast);
    lastWin  = (winCount + CNT_W'(1)) == totalWin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSrc   <= '0;
      cfgDst   <= '0;
      cfgRows  <= '0;
      cfgCols  <= '0;
      cfgWin   <= '0;
      dstPtr   <= '0;
      rowBase  <= '0;
      colBase  <= '0;
      rowOff   <= '0;
      colOff   <= '0;
      totalWin <= '0;
      winCount <= '0;
      maxVal   <= '0;
    end else begin
      if (ctrl.loadCfg) begin
        cfgSrc  <= srcBase;
        cfgDst  <= dstBase;
        cfgRows <= numRows;
        cfgCols <= numCols;
        cfgWin  <= winSize;
      end
      if (ctrl.initRun) begin
        dstPtr   <= cfgDst;
        rowBase  <= '0;
        colBase  <= '0;
        rowOff   <= '0;
        colOff   <= '0;
        winCount <= '0;
        maxVal   <= '0;
        totalWin <= outRows * outCols;
      end
      if (ctrl.scanStep) begin
        if (halfGreater(rdData, maxVal)) maxVal <= rdData;
        if (colOff == winLast) begin
          colOff <= '0;
          rowOff <= rowOff + DIM_W'(1);
        end else begin
          colOff <= colOff + DIM_W'(1);
        end
      end
      if (ctrl.writeOut) begin
        dstPtr   <= dstPtr + ADDR_W'(1);
        winCount <= winCount + CNT_W'(1);
        maxVal   <= '0;
        rowOff   <= '0;
        colOff   <= '0;
        if (rowWrap) begin
          colBase <= '0;
          rowBase <= rowBase + cfgWin;
        end else begin
          colBase <= colBase + cfgWin;
        end
      end
    end
  end

endmodule

// File: rtl/hpMaxPool.sv
module hpMaxPool
  import hpPoolPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [DIM_W-1:0]  numRows,
  input  logic [DIM_W-1:0]  numCols,
  input  logic [DIM_W-1:0]  winSize,
  output logic              done,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [15:0]       rdData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [15:0]       wrData,
  output logic              wrEn
);

  poolCtrl_t ctrl;
  logic      scanLast, lastWin;

  hpPoolCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .scanLast (scanLast),
    .lastWin  (lastWin),
    .ctrl     (ctrl),
    .wrEn     (wrEn),
    .done     (done)
  );

  hpPoolDatapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .srcBase  (srcBase),
    .dstBase  (dstBase),
    .numRows  (numRows),
    .numCols  (numCols),
    .winSize  (winSize),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .scanLast (scanLast),
    .lastWin  (lastWin)
  );

endmodule

// File: rtl/hpMaxPoolChecker.sv
module hpMaxPoolChecker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [15:0]       wrData
);

  logic              seenWr;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenWr   <= 1'b0;
      prevAddr <= '0;
    end else if (done) begin
      seenWr   <= 1'b0;
    end else if (wrEn) begin
      seenWr   <= 1'b1;
      prevAddr <= wrAddr;
    end
  end

  assert_done_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !done);

  assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_nonneg_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !wrData[15]);

  assert_consecutive_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && seenWr) |-> (wrAddr == prevAddr + ADDR_W'(1)));

  assert_write_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !done);

  assert_write_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

endmodule

bind hpMaxPool hpMaxPoolChecker #(.ADDR_W(ADDR_W)) i_checker (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .done   (done),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData)
);

// File: tb/test_hpMaxPool.sv
module test_hpMaxPool;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] srcBase = '0, dstBase = '0;
  logic [7:0]  numRows = '0, numCols = '0, winSize = '0;
  logic        done, wrEn;
  logic [15:0] rdAddr, wrAddr, wrData, rdData;

  logic [15:0] mem [0:1023];
  int checks = 0;
  int errors = 0;
  int writes = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  hpMaxPool i_hpMaxPool (
    .clk(clk), .rstN(rstN), .start(start), .srcBase(srcBase), .dstBase(dstBase),
    .numRows(numRows), .numCols(numCols), .winSize(winSize), .done(done),
    .rdAddr(rdAddr), .rdData(rdData), .wrAddr(wrAddr), .wrData(wrData), .wrEn(wrEn)
  );

  assign rdData = mem[rdAddr[9:0]];

  always @(posedge clk) begin
    if (wrEn) begin
      mem[wrAddr[9:0]] <= wrData;
      writes <= writes + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  function automatic int keyOf(input logic [15:0] v);
    return v[15] ? -int'(v[14:0]) : int'(v[14:0]);
  endfunction

  function automatic logic [15:0] genVal(input int seed, input int i);
    int unsigned x;
    x = (32'(i) * 32'd2654435761) ^ (32'(seed) * 32'd40503 + 32'd977);
    x = x ^ (x >> 13);
    x = x * 32'd1103515245;
    return x[23:8];
  endfunction

  task automatic fillRandom(input int src, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[src + i] = genVal(seed, i);
  endtask

  // Runs one job and checks timing, every result and the sentinel.
  task automatic runPool(input int src, input int dst, input int rows, input int cols,
                         input int win, input bit disturb);
    int nOut, oRows, oCols, cnt, expCnt, startWrites, maxKey;
    logic [15:0] expVal, v;
    oRows = rows / win;
    oCols = cols / win;
    nOut  = oRows * oCols;
    for (int i = 0; i < nOut + 2; i++) mem[dst + i] = 16'hDEAD;
    startWrites = writes;
    srcBase = 16'(src); dstBase = 16'(dst);
    numRows = 8'(rows); numCols = 8'(cols); winSize = 8'(win);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    check("R2 done drops after start", int'(done), 0);
    while (!done) begin
      @(negedge clk);
      cnt++;
      if (disturb && cnt == 3) begin
        // R10 / R11: scramble configuration and pulse start mid-job
        start = 1'b1;
        srcBase = 16'h0155; dstBase = 16'h0001;
        numRows = 8'd2; numCols = 8'd2; winSize = 8'd1;
      end
      if (disturb && cnt == 4) start = 1'b0;
    end
    expCnt = 2 + nOut * (win * win + 1);
    check("R7 cycles to done", cnt, expCnt);
    check("R5 write count", writes - startWrites, nOut);
    for (int orow = 0; orow < oRows; orow++) begin
      for (int ocol = 0; ocol < oCols; ocol++) begin
        maxKey = 0;
        expVal = 16'h0000;
        for (int r = 0; r < win; r++) begin
          for (int c = 0; c < win; c++) begin
            v = mem[src + (orow * win + r) * cols + ocol * win + c];
            if (keyOf(v) > maxKey) begin
              maxKey = keyOf(v);
              expVal = v;
            end
          end
        end
        check(disturb ? "R10 R11 R3 R8 result" : "R3 R5 R8 result",
              int'(mem[dst + orow * oCols + ocol]), int'(expVal));
      end
    end
    check("R6 no write past last result", int'(mem[dst + nOut]), 16'hDEAD);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1 done after reset", int'(done), 1);
    check("R1 wrEn after reset", int'(wrEn), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 done holds while idle", int'(done), 1);

    // R3: directed ordering cases, 2x6 matrix with three 2x2 windows.
    // window0: exponent beats mantissa -> 3C00; window1: +tiny beats large negative -> 0001;
    // window2: mantissa decides -> 4001
    mem[10] = 16'h3BFF; mem[11] = 16'h3C00; mem[12] = 16'h8000; mem[13] = 16'hC000;
    mem[14] = 16'h4000; mem[15] = 16'h3FFF;
    mem[16] = 16'hFC00; mem[17] = 16'h0001; mem[18] = 16'h0001; mem[19] = 16'h0000;
    mem[20] = 16'h4001; mem[21] = 16'h3C00;
    runPool(10, 600, 2, 6, 2, 1'b0);
    check("R3 exponent wins", int'(mem[600]), 16'h3C00);
    check("R3 positive beats negative", int'(mem[601]), 16'h0001);
    check("R3 mantissa wins", int'(mem[602]), 16'h4001);

    // R4: all-negative and signed-zero windows give +0.0
    mem[30] = 16'h8000; mem[31] = 16'hFC00; mem[32] = 16'h8001; mem[33] = 16'hC000;
    runPool(30, 620, 2, 2, 2, 1'b0);
    check("R4 all-negative window", int'(mem[620]), 16'h0000);
    for (int i = 0; i < 9; i++) mem[40 + i] = 16'h8000 | 16'(i * 97);
    runPool(40, 630, 3, 3, 3, 1'b0);
    check("R4 negative 3x3 window", int'(mem[630]), 16'h0000);

    // Sweep of shapes, window sizes and source offsets
    fillRandom(100, 16, 1);  runPool(100, 640, 4, 4, 2, 1'b0);
    fillRandom(101, 36, 2);  runPool(101, 660, 6, 6, 2, 1'b0);
    fillRandom(137, 36, 3);  runPool(137, 680, 6, 6, 3, 1'b0);
    fillRandom(200, 35, 4);  runPool(200, 700, 5, 7, 2, 1'b0);   // R6 trailing row/col
    fillRandom(250, 9, 5);   runPool(250, 720, 3, 3, 1, 1'b0);
    fillRandom(260, 64, 6);  runPool(260, 740, 8, 8, 4, 1'b0);
    fillRandom(330, 40, 7);  runPool(330, 760, 5, 8, 3, 1'b0);   // R6 partial window skipped
    fillRandom(8, 676, 8);   runPool(8, 800, 26, 26, 2, 1'b0);   // 13x13 output

    // R10 / R11: configuration change and start pulse during a job
    fillRandom(120, 36, 9);  runPool(120, 990, 6, 6, 2, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule